// File: doc/BRIEF.md
# Bus Wake Filter with Stuck-Dominant Lockout

This block watches a single-wire bus while the transceiver it serves is asleep and decides when a remote node has asked for wake-up. The bus level reaches it already digitised and synchronous to the clock, with 0 meaning dominant and 1 meaning recessive. A wake-up request is a dominant stretch at least `DOM_CYCLES` samples long. The block signals it with a single-cycle `wake_pulse` once the bus returns to recessive.

A bus that is stuck low would otherwise wake the node, let it fall asleep and wake it again, drawing current each time. To prevent this, the bus level is sampled at the moment sleep is entered. If the bus is dominant at that point, wake detection is locked out. The lockout is released only after `REC_CYCLES` consecutive recessive samples. While `sleep_active` is low the block is held idle.

The controller has five states:
- `ST_IDLE`: the block is not in sleep.
- `ST_LOCKED`: lockout, counting recessive samples.
- `ST_ARMED`: waiting for a dominant level.
- `ST_DOM`: counting dominant samples.
- `ST_QUAL`: dominant long enough, waiting for recessive.

Its transitions are:
- IDLE→ARMED: entry strobe while the bus is recessive.
- IDLE→LOCKED: entry strobe while the bus is dominant.
- LOCKED→ARMED: the `REC_CYCLES`-th consecutive recessive sample.
- ARMED→DOM: a dominant sample.
- DOM→ARMED: a recessive sample before qualification.
- DOM→QUAL: the `DOM_CYCLES`-th dominant sample.
- QUAL→ARMED: a recessive sample, which also emits the pulse.
- any state→IDLE: `sleep_active` low.

Top module: `bus_wake_filter`

## Requirements
- R1: After reset, `wake_pulse` and `locked_out` are 0 and the controller is in `ST_IDLE`.
- R2: At a clock edge where `sleep_active` and `sleep_enter` are both 1 in `ST_IDLE`, the bus level decides the next state. A dominant level (0) makes `locked_out` 1 from the next cycle. A recessive level (1) leaves `locked_out` at 0 and arms detection.
- R3: Once locked, `locked_out` falls in the cycle after the `REC_CYCLES`-th consecutive recessive sample, and not earlier.
- R4: A dominant sample during the recessive clear interval restarts that count from zero, so `locked_out` stays 1.
- R5: While `locked_out` is 1, no dominant stretch of any length produces a `wake_pulse`.
- R6: A wake needs at least `DOM_CYCLES` consecutive dominant samples while armed; shorter dominant stretches produce no pulse (`DOM_CYCLES` at least 2).
- R7: `wake_pulse` is 1 for exactly one cycle, in the cycle after the edge that samples the first recessive level following a qualified dominant stretch. There is no pulse while the bus stays dominant, however long.
- R8: A single recessive sample inside a dominant stretch that is not yet qualified restarts the dominant count.
- R9: While `sleep_active` is 0 the block returns to `ST_IDLE`, clears both counters, and keeps `wake_pulse` and `locked_out` at 0. Dropping `sleep_active` after qualification cancels the pending pulse.
- R10: Raising `sleep_active` without an entry strobe does not arm detection; dominant stretches then produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_level | input | 1 | Digitised bus level, 0 = dominant, 1 = recessive |
| sleep_active | input | 1 | High while the transceiver is in sleep |
| sleep_enter | input | 1 | One-cycle strobe marking entry to sleep |
| wake_pulse | output | 1 | One-cycle remote wake indication |
| locked_out | output | 1 | High while wake detection is locked out |

## Verification
Every result is registered once, so each output reflects the inputs sampled at the previous rising edge. The bench changes inputs on the falling edge and reads outputs at the next falling edge.

`locked_out` is therefore due one cycle after the entry strobe, or one cycle after the `REC_CYCLES`-th recessive sample. `wake_pulse` is due one cycle after the first recessive sample that follows `DOM_CYCLES` dominant ones.

For each phase, the bench counts the pulses seen in every cycle, so both an early pulse and a late pulse show up as a wrong count in the phase where they occur.

// File: rtl/bwf_pkg.sv
package bwf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOCKED = 3'd1,
        ST_ARMED  = 3'd2,
        ST_DOM    = 3'd3,
        ST_QUAL   = 3'd4
    } bwf_state_t;

endpackage

// File: rtl/bwf_run_counter.sv
// Counts consecutive qualifying samples; cleared whenever a sample does not qualify.
module bwf_run_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    output logic at_limit
);
    localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign at_limit = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!inc) begin
            cnt <= '0;
        end else if (!at_limit) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bwf_fsm.sv
module bwf_fsm
    import bwf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_level,
    input  logic       sleep_active,
    input  logic       sleep_enter,
    input  logic       dom_hit,
    input  logic       rec_hit,
    output bwf_state_t state,
    output logic       dom_inc,
    output logic       rec_inc,
    output logic       wake_pulse,
    output logic       locked_out
);
    bwf_state_t nxt;

    // next-state decision
    always_comb begin
        nxt = state;
        if (!sleep_active) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (sleep_enter) nxt = bus_level ? ST_ARMED : ST_LOCKED;
                ST_LOCKED: if (bus_level && rec_hit) nxt = ST_ARMED;
                ST_ARMED:  if (!bus_level) nxt = ST_DOM;
                ST_DOM: begin
                    if (bus_level)    nxt = ST_ARMED;
                    else if (dom_hit) nxt = ST_QUAL;
                end
                ST_QUAL:   if (bus_level) nxt = ST_ARMED;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_pulse <= 1'b0;
        else        wake_pulse <= sleep_active && bus_level && (state == ST_QUAL);
    end

    assign locked_out = (state == ST_LOCKED);
    assign dom_inc = sleep_active && !bus_level &&
                     ((state == ST_ARMED) || (state == ST_DOM));
    assign rec_inc = sleep_active && bus_level && (state == ST_LOCKED);
endmodule

// File: rtl/bus_wake_filter.sv
module bus_wake_filter
    import bwf_pkg::*;
#(
    parameter int DOM_CYCLES = 25000,
    parameter int REC_CYCLES = 4250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_level,
    input  logic sleep_active,
    input  logic sleep_enter,
    output logic wake_pulse,
    output logic locked_out
);
    bwf_state_t state;
    logic dom_inc, rec_inc, dom_hit, rec_hit;

    bwf_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_level    (bus_level),
        .sleep_active (sleep_active),
        .sleep_enter  (sleep_enter),
        .dom_hit      (dom_hit),
        .rec_hit      (rec_hit),
        .state        (state),
        .dom_inc      (dom_inc),
        .rec_inc      (rec_inc),
        .wake_pulse   (wake_pulse),
        .locked_out   (locked_out)
    );

    bwf_run_counter #(.LIMIT(DOM_CYCLES)) u_dom_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (dom_inc),
        .at_limit (dom_hit)
    );

    bwf_run_counter #(.LIMIT(REC_CYCLES)) u_rec_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (rec_inc),
        .at_limit (rec_hit)
    );
endmodule

// File: rtl/bus_wake_filter_chk.sv
module bus_wake_filter_chk
    import bwf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_level,
    input logic       sleep_active,
    input logic       sleep_enter,
    input logic       wake_pulse,
    input logic       locked_out,
    input bwf_state_t cur_state
);
    assert_entry_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE && sleep_active && sleep_enter && !bus_level) |=> locked_out);

    assert_lock_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_active && locked_out && !bus_level) |=> locked_out);

    assert_lock_no_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        locked_out |=> !wake_pulse);

    assert_wake_after_dominant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> ($past(bus_level) && !$past(bus_level, 2)));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    assert_idle_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_active |=> !wake_pulse);

    assert_idle_no_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_active |=> !locked_out);
endmodule

bind bus_wake_filter bus_wake_filter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_level    (bus_level),
    .sleep_active (sleep_active),
    .sleep_enter  (sleep_enter),
    .wake_pulse   (wake_pulse),
    .locked_out   (locked_out),
    .cur_state    (state)
);

// File: tb/tb_bus_wake_filter.sv
`timescale 1ns/1ps
module tb_bus_wake_filter;
    localparam int DOM = 10;
    localparam int REC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_level = 1'b1;
    logic sleep_active = 1'b0;
    logic sleep_enter = 1'b0;
    logic wake_pulse, locked_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_wake_filter #(.DOM_CYCLES(DOM), .REC_CYCLES(REC)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_level    (bus_level),
        .sleep_active (sleep_active),
        .sleep_enter  (sleep_enter),
        .wake_pulse   (wake_pulse),
        .locked_out   (locked_out)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Hold the bus at lvl for n cycles; count pulses, then check pulses and lock state.
    task automatic drive(bit lvl, int n, int exp_pulses, int exp_lock, string req);
        int pulses = 0;
        for (int i = 0; i < n; i++) begin
            bus_level = lvl;
            @(negedge clk);
            if (wake_pulse) pulses++;
        end
        check({req, " pulses"}, pulses, exp_pulses);
        check({req, " locked_out"}, int'(locked_out), exp_lock);
    endtask

    task automatic enter_sleep(bit lvl);
        sleep_active = 1'b1;
        sleep_enter  = 1'b1;
        bus_level    = lvl;
        @(negedge clk);
        sleep_enter  = 1'b0;
    endtask

    task automatic leave_sleep();
        sleep_active = 1'b0;
        bus_level    = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 wake_pulse", int'(wake_pulse), 0);
        check("R1 locked_out", int'(locked_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_clean_wake();
        enter_sleep(1'b1);
        check("R2 recessive entry locked_out", int'(locked_out), 0);
        drive(1'b0, DOM, 0, 0, "R7 no pulse while dominant");
        drive(1'b1, 1, 1, 0, "R7 pulse on return");
        drive(1'b1, 3, 0, 0, "R7 single cycle");
    endtask

    task automatic t_short();
        drive(1'b0, DOM - 1, 0, 0, "R6 short dominant");
        drive(1'b1, 3, 0, 0, "R6 short ignored");
    endtask

    task automatic t_long();
        drive(1'b0, 4 * DOM, 0, 0, "R7 long dominant");
        drive(1'b1, 2, 1, 0, "R7 pulse after long");
    endtask

    task automatic t_glitch();
        drive(1'b0, 6, 0, 0, "R8 first half");
        drive(1'b1, 1, 0, 0, "R8 glitch");
        drive(1'b0, 6, 0, 0, "R8 second half");
        drive(1'b1, 3, 0, 0, "R8 restarted count");
        drive(1'b0, DOM, 0, 0, "R8 full stretch");
        drive(1'b1, 1, 1, 0, "R8 wake after full");
    endtask

    task automatic t_lockout();
        leave_sleep();
        enter_sleep(1'b0);
        check("R2 dominant entry locked_out", int'(locked_out), 1);
        drive(1'b0, 4 * DOM, 0, 1, "R5 stuck dominant");
        drive(1'b1, 2, 0, 1, "R5 release no pulse");
        drive(1'b1, REC - 3, 0, 1, "R4 partial clear");
        drive(1'b0, 1, 0, 1, "R4 dominant glitch");
        drive(1'b1, REC - 1, 0, 1, "R3 one short of clear");
        drive(1'b1, 1, 0, 0, "R3 cleared");
        drive(1'b0, DOM, 0, 0, "R3 armed dominant");
        drive(1'b1, 1, 1, 0, "R3 wake after clear");
    endtask

    task automatic t_idle();
        drive(1'b0, DOM, 0, 0, "R9 qualify");
        sleep_active = 1'b0;
        drive(1'b1, 3, 0, 0, "R9 drop cancels pulse");
        drive(1'b0, 3 * DOM, 0, 0, "R9 idle dominant");
        drive(1'b1, 2, 0, 0, "R9 idle return");
        sleep_active = 1'b1;
        drive(1'b0, 2 * DOM, 0, 0, "R10 no strobe dominant");
        drive(1'b1, 2, 0, 0, "R10 no strobe return");
        leave_sleep();
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end

    initial begin
        t_reset();
        t_clean_wake();
        t_short();
        t_long();
        t_glitch();
        t_lockout();
        t_idle();
        summary();
    end
endmodule